// File: doc/BRIEF.md
# Lane-Parallel Dot-Product Accumulator

This block computes a running dot product over a stream of vector beats. Each beat carries `LANES` pairs of unsigned 8-bit operands. Every lane has its own pipelined multiplier, and all lanes work on the same beat. A registered binary adder tree reduces the products to a single dot product. A one-stage accumulator then adds that dot product to a 32-bit running total, or loads the total with it.

Every input beat is marked with a valid flag. A beat can also be marked as the first of a new accumulation, which replaces the old total without a separate clear cycle. The beat controls travel through a shift register that has the same depth as the multiplier and tree stages. Because of this, each control arrives at the accumulator in the same cycle as the dot product it belongs to. The block accepts one beat per cycle and has a fixed latency that depends only on the lane count.

Top module: `dot_accum`

## Requirements
- R1: While reset (`rst_n` low) is held, and right after it, `acc_sum` is 0 and `res_vld` is 0.
- R2: Lane i takes its operands from bits [8i+7:8i] of `op_a` and `op_b`. Both operands are unsigned. For a beat that has `in_first` set, `acc_sum` becomes the sum over all lanes of a_i*b_i.
- R3: For a valid beat that has `in_first` clear, the dot product is added to the previous `acc_sum`, modulo 2^32.
- R4: For a valid beat that has `in_first` set, the earlier total is discarded and `acc_sum` is loaded with that beat's dot product. This applies even in the middle of a back-to-back stream.
- R5: The latency is LAT = 3 + max(2, ceil(log2 LANES)) + 1 cycles. A beat sampled at clock edge k updates `acc_sum` at edge k+LAT-1. `res_vld` is high for exactly one cycle for each valid beat.
- R6: The block accepts a new beat on every cycle (initiation interval 1). Every beat in a back-to-back run produces its own correct result.
- R7: A cycle with `in_vld` low has no effect: `acc_sum` holds its value and `in_first` is ignored.
- R8: The dot product never exceeds LANES*65025. The total of 1000 beats of all-255 operands is exact (260,100,000 for 4 lanes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | The beat on the operand inputs is valid |
| in_first | input | 1 | This beat starts a new accumulation |
| op_a | input | LANES*8 | Packed A operands, lane 0 in the low byte |
| op_b | input | LANES*8 | Packed B operands, lane 0 in the low byte |
| acc_sum | output | 32 | Running accumulated total |
| res_vld | output | 1 | `acc_sum` was updated by a beat on this cycle |

## Verification
If the sideband pipe and the data pipe fall out of step, results show up at the wrong cycle: `res_vld` is compared against the expected issue cycle plus LAT, so the very first beat exposes a depth error. A wrong product, a wrong lane mapping or a mistake in the tree padding corrupts the sum on the first beat with distinct lane values. A load that wrongly adds, or an add that wrongly loads, shows up on the next result after a restart. If the tree is one bit too narrow, the result is wrong on the first all-255 beat. An accumulator that drifts during idle cycles is caught at the next idle sample.

// File: rtl/dot_accum_pkg.sv
package dot_accum_pkg;
  localparam int MUL_LAT = 3;

  function automatic int tree_levels(input int n);
    return (n <= 1) ? 0 : $clog2(n);
  endfunction

  function automatic int tree_depth(input int n);
    return (tree_levels(n) < 2) ? 2 : tree_levels(n);
  endfunction

  function automatic longint max_dot(input int n, input int opw);
    longint m;
    m = (longint'(1) << opw) - 1;
    return longint'(n) * m * m;
  endfunction
endpackage

// File: rtl/lane_mul.sv
module lane_mul #(
  parameter int OPW = 8,
  localparam int PW = 2 * OPW
) (
  input  logic          clk,
  input  logic [OPW-1:0] a,
  input  logic [OPW-1:0] b,
  output logic [PW-1:0]  p
);
  logic [OPW-1:0] a_q, b_q;
  logic [PW-1:0]  p_q;

  always_ff @(posedge clk) begin
    a_q <= a;
    b_q <= b;
    p_q <= a_q * b_q;
    p   <= p_q;
  end
endmodule

// File: rtl/add_tree.sv
module add_tree
  import dot_accum_pkg::*;
#(
  parameter int N  = 4,
  parameter int PW = 16,
  localparam int LV   = tree_levels(N),
  localparam int P    = 1 << LV,
  localparam int D    = tree_depth(N),
  localparam int PASS = D - LV,
  localparam int TW   = PW + LV
) (
  input  logic          clk,
  input  logic [N*PW-1:0] prod,
  output logic [TW-1:0]   dot
);
  for (genvar l = 0; l <= LV; l++) begin : g_lvl
    localparam int W = P >> l;
    logic [W*TW-1:0] v;
    if (l == 0) begin : g_in
      for (genvar j = 0; j < P; j++) begin : g_pad
        if (j < N) begin : g_real
          assign v[j*TW +: TW] = TW'(prod[j*PW +: PW]);
        end else begin : g_zero
          assign v[j*TW +: TW] = '0;
        end
      end
    end else begin : g_add
      always_ff @(posedge clk) begin
        for (int j = 0; j < W; j++) begin
          v[j*TW +: TW] <= g_lvl[l-1].v[2*j*TW +: TW] + g_lvl[l-1].v[(2*j+1)*TW +: TW];
        end
      end
    end
  end

  logic [TW-1:0] pipe [0:PASS];
  assign pipe[0] = g_lvl[LV].v;

  for (genvar s = 1; s <= PASS; s++) begin : g_pass
    always_ff @(posedge clk) pipe[s] <= pipe[s-1];
  end

  assign dot = pipe[PASS];
endmodule

// File: rtl/accum_stage.sv
module accum_stage #(
  parameter int TW   = 18,
  parameter int ACCW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic           load,
  input  logic [TW-1:0]  dot,
  output logic [ACCW-1:0] sum,
  output logic           rv
);
  logic [ACCW-1:0] dot_ext;
  assign dot_ext = ACCW'(dot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum <= '0;
      rv  <= 1'b0;
    end else begin
      rv <= fire;
      if (fire) sum <= load ? dot_ext : sum + dot_ext;
    end
  end
endmodule

// File: rtl/dot_accum.sv
module dot_accum
  import dot_accum_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OPW   = 8,
  parameter int ACCW  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_vld,
  input  logic               in_first,
  input  logic [LANES*OPW-1:0] op_a,
  input  logic [LANES*OPW-1:0] op_b,
  output logic [ACCW-1:0]    acc_sum,
  output logic               res_vld
);
  localparam int PW  = 2 * OPW;
  localparam int D   = tree_depth(LANES);
  localparam int TW  = PW + tree_levels(LANES);
  localparam int SB  = MUL_LAT + D;
  localparam int LAT = SB + 1;

  logic [LANES*PW-1:0] prod;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lane_mul #(.OPW(OPW)) u_mul (
      .clk(clk),
      .a  (op_a[i*OPW +: OPW]),
      .b  (op_b[i*OPW +: OPW]),
      .p  (prod[i*PW +: PW])
    );
  end

  logic [TW-1:0] dot_at_acc;

  add_tree #(.N(LANES), .PW(PW)) u_tree (
    .clk (clk),
    .prod(prod),
    .dot (dot_at_acc)
  );

  logic [SB-1:0] vld_sr, first_sr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_sr   <= '0;
      first_sr <= '0;
    end else begin
      vld_sr   <= {vld_sr[SB-2:0], in_vld};
      first_sr <= {first_sr[SB-2:0], in_first};
    end
  end

  logic acc_fire, acc_load;
  assign acc_fire = vld_sr[SB-1];
  assign acc_load = first_sr[SB-1];

  accum_stage #(.TW(TW), .ACCW(ACCW)) u_acc (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (acc_fire),
    .load (acc_load),
    .dot  (dot_at_acc),
    .sum  (acc_sum),
    .rv   (res_vld)
  );
endmodule

// File: rtl/dot_accum_chk.sv
module dot_accum_chk #(
  parameter int LANES = 4,
  parameter int OPW   = 8,
  parameter int ACCW  = 32,
  parameter int TW    = 18,
  parameter int LAT   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_vld,
  input logic            res_vld,
  input logic            acc_fire,
  input logic            acc_load,
  input logic [TW-1:0]   dot_at_acc,
  input logic [ACCW-1:0] acc_sum
);
  logic [LAT-1:0] vld_hist;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_hist <= '0;
    else        vld_hist <= {vld_hist[LAT-2:0], in_vld};
  end

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld == vld_hist[LAT-1]);

  assert_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !acc_load) |=> acc_sum == $past(acc_sum) + ACCW'($past(dot_at_acc)));

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && acc_load) |=> acc_sum == ACCW'($past(dot_at_acc)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_fire |=> ($stable(acc_sum) && !res_vld));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |-> (64'(dot_at_acc) <= 64'(dot_accum_pkg::max_dot(LANES, OPW))));
endmodule

bind dot_accum dot_accum_chk #(
  .LANES(LANES), .OPW(OPW), .ACCW(ACCW), .TW(TW), .LAT(LAT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_vld    (in_vld),
  .res_vld   (res_vld),
  .acc_fire  (acc_fire),
  .acc_load  (acc_load),
  .dot_at_acc(dot_at_acc),
  .acc_sum   (acc_sum)
);

// File: tb/tb_dot_accum.sv
module tb_dot_accum;
  localparam int LANES = 4;
  localparam int LV    = (LANES <= 1) ? 0 : $clog2(LANES);
  localparam int LAT   = 3 + ((LV < 2) ? 2 : LV) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0, in_first = 1'b0;
  logic [LANES*8-1:0] op_a = '0, op_b = '0;
  logic [31:0] acc_sum;
  logic res_vld;

  dot_accum #(.LANES(LANES)) dut (.*);

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] model = '0;
  logic [31:0] exp_sum [0:4095];
  int          exp_cyc [0:4095];
  int          exp_req [0:4095];
  int wr = 0, rd = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n && res_vld) begin
      if (rd >= wr) chk(1'b0, "R5 spurious res_vld", rd, wr);
      else begin
        chk(acc_sum == exp_sum[rd], exp_req[rd] == 4 ? "R4 sum" : exp_req[rd] == 3 ? "R3 sum" : "R2 sum",
            acc_sum, exp_sum[rd]);
        chk(cyc == exp_cyc[rd], "R5 latency", cyc, exp_cyc[rd]);
        rd++;
      end
    end
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
  end

  task automatic beat(input logic [LANES*8-1:0] a, input logic [LANES*8-1:0] b,
                      input bit first, input bit vld);
    @(negedge clk);
    op_a = a; op_b = b; in_first = first; in_vld = vld;
    if (vld) begin
      logic [31:0] dot = '0;
      for (int i = 0; i < LANES; i++) dot += 32'(a[i*8 +: 8]) * 32'(b[i*8 +: 8]);
      model = first ? dot : model + dot;
      exp_sum[wr] = model;
      exp_cyc[wr] = cyc + LAT;
      exp_req[wr] = first ? 4 : 3;
      wr++;
    end
  endtask

  task automatic idle_input();
    @(negedge clk);
    in_vld = 1'b0; in_first = 1'b0;
  endtask

  task automatic drain();
    idle_input();
    repeat (LAT + 2) @(negedge clk);
    chk(rd == wr, "R5 result count", rd, wr);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(acc_sum == 0, "R1 sum in reset", acc_sum, 0);
    chk(res_vld == 1'b0, "R1 valid in reset", res_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(acc_sum == 0, "R1 sum after reset", acc_sum, 0);
    chk(res_vld == 1'b0, "R1 valid after reset", res_vld, 0);
  endtask

  task automatic t_single_R2();
    beat({8'd255, 8'd3, 8'd2, 8'd1}, {8'd7, 8'd40, 8'd200, 8'd9}, 1'b1, 1'b1);
    drain();
    chk(acc_sum == 32'd2314, "R2 lane mapping", acc_sum, 2314);
  endtask

  task automatic t_idle_R7();
    logic [31:0] held;
    held = acc_sum;
    for (int k = 0; k < 10; k++) begin
      beat({LANES{8'd99}}, {LANES{8'd77}}, 1'b1, 1'b0);
    end
    repeat (LAT + 1) @(negedge clk);
    chk(acc_sum == held, "R7 idle hold", acc_sum, held);
    chk(res_vld == 1'b0, "R7 no valid", res_vld, 0);
  endtask

  task automatic t_stream_R6();
    for (int k = 0; k < 300; k++) begin
      beat({$urandom, $urandom}, {$urandom, $urandom}, (k % 37) == 0, 1'b1);
    end
    drain();
    for (int k = 0; k < 200; k++) begin
      beat({$urandom}, {$urandom}, ($urandom % 20) == 0, ($urandom % 3) != 0);
    end
    drain();
  endtask

  task automatic t_restart_R4();
    beat({LANES{8'd10}}, {LANES{8'd10}}, 1'b0, 1'b1);
    beat({LANES{8'd1}}, {LANES{8'd2}}, 1'b1, 1'b1);
    beat({LANES{8'd1}}, {LANES{8'd1}}, 1'b0, 1'b1);
    drain();
    chk(acc_sum == 32'(LANES * 3), "R4 restart mid stream", acc_sum, LANES * 3);
  endtask

  task automatic t_worst_R8();
    for (int k = 0; k < 1000; k++) begin
      beat({LANES{8'hFF}}, {LANES{8'hFF}}, k == 0, 1'b1);
    end
    drain();
    chk(acc_sum == 32'(1000 * LANES * 65025), "R8 worst case total", acc_sum, 1000 * LANES * 65025);
  endtask

  initial begin
    t_reset();
    t_single_R2();
    t_idle_R7();
    t_stream_R6();
    t_restart_R4();
    t_worst_R8();
    t_idle_R7();
    finish_run();
  end
endmodule